// File: doc/BRIEF.md
# Two-Channel External Interrupt Controller

This block turns activity on two external pins into interrupt requests for a small processor core. Each pin is brought into the clock domain through a two-flop synchroniser and then watched according to a per-channel 2-bit sense selection: low level, any change, falling edge or rising edge. An edge event latches a per-channel pending flag. In level mode nothing is latched, and the request follows the synchronised pin directly.

Software sees two byte-wide registers on a simple register bus: an enable mask and the pending flags. A request reaches the core only when the channel is pending, its mask bit is one and the global interrupt-enable input is one. When both channels request at once, channel 0 is presented first. The core acknowledges with a one-hot channel select, which clears that channel's flag. Writing a one to a flag bit also clears it. The pad value is sampled whatever the pin's direction, so a pin driven as an output still triggers detection. The sense selection arrives as plain inputs.

Top module: `xint_ctrl`

## Requirements
- R1: After reset both registers read 0x00 and `irq_o` and `irq_id_o` are zero.
- R2: The mask register is at address 0x1D and the flag register at address 0x1C. Bit 0 belongs to channel 0 and bit 1 to channel 1. Bits 7 down to 2 always read zero and ignore writes. Any other address reads 0x00, and a write to it changes nothing.
- R3: The sense code for channel n is `sense_i[2n+1:2n]`: 2'b01 means any change, 2'b10 means a falling edge and 2'b11 means a rising edge. Take the pin change to be sampled at clock edge k. The matching flag then reads one after edge k+2.
- R4: `irq_o` is one exactly when some channel is pending, has its mask bit at one, and `gie_i` is one.
- R5: A bus write of one to a flag bit at 0x1C clears that flag at the next edge. A write of zero leaves the flag unchanged.
- R6: An acknowledge pulse on `ack_i[n]` clears the flag of channel n and no other flag.
- R7: If a detection and a clear (by write or by acknowledge) reach one channel in the same cycle, the flag is set.
- R8: With sense code 2'b00 (low level), the channel's flag reads zero and is cleared if it was set. The channel is pending while its synchronised pin is low, with a latency of two clock edges from the sampled pin.
- R9: `irq_id_o` is one-hot, naming the lowest-numbered requesting channel. It is zero when `irq_o` is zero.
- R10: Flags latch events even while the channel's mask bit or `gie_i` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 2 | External pin pad values, one per channel |
| sense_i | input | 4 | Sense code, two bits per channel |
| gie_i | input | 1 | Global interrupt enable from the core |
| bus_addr_i | input | 6 | Register bus address |
| bus_we_i | input | 1 | Register bus write strobe |
| bus_wdata_i | input | 8 | Register bus write data |
| bus_rdata_o | output | 8 | Register bus read data for `bus_addr_i` |
| ack_i | input | 2 | One-hot acknowledge of the vector taken |
| irq_o | output | 1 | Interrupt request to the core |
| irq_id_o | output | 2 | One-hot channel currently presented |

## Verification
The pins are driven with slow square waves, with isolated single edges, and with a pattern that toggles on every cycle. Running these under each of the three edge codes distinguishes rising, falling and any-change detection, and it also exposes a wrong synchroniser latency. Clears are raced against detections on the same cycle, which separates set-wins behaviour from clear-wins behaviour. Level mode is run with a flag that was left set by an earlier edge mode, with both pins low together, and with the mask and enable toggled. These cases confirm that the flag stays zero, that the request follows the pin, and that channel 0 takes priority.

// File: rtl/xint_pkg.sv
// Package: shared types for the external interrupt controller.
// Assumes: sense code width of two bits per channel.
package xint_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

endpackage

// File: rtl/xint_sync.sv
// Module: xint_sync
// Brings one asynchronous pad value into the clock domain through a
// shift chain of STAGES flops. It also keeps the synchronised value from
// one clock earlier, for edge detection.
// Assumes: STAGES >= 2. Reset clears the chain, so the pin is taken as low
// at reset release.
module xint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic cur_o,
    output logic prev_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the pad value through the synchroniser and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign cur_o  = chain_q[STAGES-1];
    assign prev_o = prev_q;

endmodule

// File: rtl/xint_chan.sv
// Module: xint_chan
// Per-channel detector and pending flag. It decodes the sense code against
// the current and previous synchronised pin values, keeps the edge flag,
// and produces the channel's pending condition.
// Assumes: clr_i already merges the write-one clear and the acknowledge.
module xint_chan
    import xint_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cur_i,
    input  logic   prev_i,
    input  sense_e sense_i,
    input  logic   clr_i,
    output logic   flag_o,
    output logic   pend_o
);

    logic det;
    logic flag_q;
    logic flag_d;

    // Select the detection condition for the programmed sense code.
    always_comb begin
        unique case (sense_i)
            SENSE_ANY:  det = cur_i ^ prev_i;
            SENSE_FALL: det = prev_i & ~cur_i;
            SENSE_RISE: det = cur_i & ~prev_i;
            default:    det = 1'b0;
        endcase
    end

    // Next flag: level mode forces zero, a detection beats any clear.
    always_comb begin
        if (sense_i == SENSE_LOW)  flag_d = 1'b0;
        else if (det)              flag_d = 1'b1;
        else if (clr_i)            flag_d = 1'b0;
        else                       flag_d = flag_q;
    end

    // Hold the pending edge flag.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
    assign pend_o = (sense_i == SENSE_LOW) ? ~cur_i : flag_q;

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (det && sense_i != SENSE_LOW) |=> flag_q);

    // R5
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !det && flag_q) |=> !flag_q);

    // R8
    lvl_flag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_i == SENSE_LOW) |=> !flag_q);

endmodule

// File: rtl/xint_prio.sv
// Module: xint_prio
// Fixed-priority picker. The lowest-numbered active request wins, and the
// result is one-hot.
// Assumes: N >= 1.
module xint_prio #(
    parameter int N = 2
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o
);

    logic taken;

    // Scan upward and mark only the first active request.
    always_comb begin
        grant_o = '0;
        taken   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !taken) begin
                grant_o[i] = 1'b1;
                taken      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/xint_ctrl.sv
// Module: xint_ctrl
// Top of the external interrupt controller. It instantiates one
// synchroniser and one detector per channel. It holds the enable mask,
// decodes the register bus and forms the prioritised request.
// Assumes: NCH < DATA_W. Reads are combinational on the address.
module xint_ctrl
    import xint_pkg::*;
#(
    parameter int                NCH       = 2,
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 6,
    parameter int                SYNC_LEN  = 2,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 6'h1D,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    pin_i,
    input  logic [2*NCH-1:0]  sense_i,
    input  logic              gie_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [NCH-1:0]    ack_i,
    output logic              irq_o,
    output logic [NCH-1:0]    irq_id_o
);

    localparam int RSV_W = DATA_W - NCH;

    logic [NCH-1:0] mask_q;
    logic [NCH-1:0] cur;
    logic [NCH-1:0] prv;
    logic [NCH-1:0] flag;
    logic [NCH-1:0] pend;
    logic [NCH-1:0] clr;
    logic [NCH-1:0] req;
    logic           mask_wr;
    logic           flag_wr;
    logic           unused_wdata_hi;

    assign mask_wr         = bus_we_i && (bus_addr_i == MASK_ADDR);
    assign flag_wr         = bus_we_i && (bus_addr_i == FLAG_ADDR);
    assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:NCH];

    // Keep the enable mask, written only at its own address.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= bus_wdata_i[NCH-1:0];
    end

    // Merge the write-one clear with the core acknowledge.
    always_comb begin
        clr = ack_i;
        if (flag_wr) clr = clr | bus_wdata_i[NCH-1:0];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        xint_sync #(.STAGES(SYNC_LEN)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_i[g]),
            .cur_o  (cur[g]),
            .prev_o (prv[g])
        );
        xint_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .cur_i   (cur[g]),
            .prev_i  (prv[g]),
            .sense_i (sense_e'(sense_i[2*g +: 2])),
            .clr_i   (clr[g]),
            .flag_o  (flag[g]),
            .pend_o  (pend[g])
        );
    end

    assign req   = pend & mask_q & {NCH{gie_i}};
    assign irq_o = |req;

    xint_prio #(.N(NCH)) u_prio (
        .req_i   (req),
        .grant_o (irq_id_o)
    );

    // Return the addressed register, reserved bits as zero.
    always_comb begin
        if (bus_addr_i == MASK_ADDR)      bus_rdata_o = {{RSV_W{1'b0}}, mask_q};
        else if (bus_addr_i == FLAG_ADDR) bus_rdata_o = {{RSV_W{1'b0}}, flag};
        else                              bus_rdata_o = '0;
    end

    // R4
    irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> gie_i);

    // R9
    id_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_id_o));

    // R9
    ch0_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && mask_q[0] && gie_i) |-> (irq_id_o[0] && irq_o));

    // R2
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_o[DATA_W-1:NCH] == '0);

endmodule

// File: tb/xint_ctrl_tb.sv
// Bench for xint_ctrl: a behavioural reference model, updated at every
// rising edge, compared with the outputs at every falling edge.
module xint_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] pin_i;
    logic [3:0] sense_i;
    logic       gie_i;
    logic [5:0] bus_addr_i;
    logic       bus_we_i;
    logic [7:0] bus_wdata_i;
    logic [7:0] bus_rdata_o;
    logic [1:0] ack_i;
    logic       irq_o;
    logic [1:0] irq_id_o;

    int    n_cmp  = 0;
    int    n_bad  = 0;
    string tag    = "R1";

    // Reference state
    bit    hist [2][$];
    int    m_mask;
    int    m_flag [2];

    always #5 clk = ~clk;

    xint_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pin_i),
        .sense_i     (sense_i),
        .gie_i       (gie_i),
        .bus_addr_i  (bus_addr_i),
        .bus_we_i    (bus_we_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .ack_i       (ack_i),
        .irq_o       (irq_o),
        .irq_id_o    (irq_id_o)
    );

    // Model update: two sync stages plus one history sample per pin.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = 0;
            for (int c = 0; c < 2; c++) begin
                m_flag[c] = 0;
                hist[c].delete();
                repeat (3) hist[c].push_back(1'b0);
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                int mode;
                bit now_v, old_v, hit, wipe;
                mode  = int'(sense_i[2*c +: 2]);
                now_v = hist[c][1];
                old_v = hist[c][2];
                hit   = (mode == 1 && now_v != old_v) ||
                        (mode == 2 && old_v && !now_v) ||
                        (mode == 3 && now_v && !old_v);
                wipe  = ack_i[c] || (bus_we_i && bus_addr_i == 6'h1C && bus_wdata_i[c]);
                if (mode == 0)  m_flag[c] = 0;
                else if (hit)   m_flag[c] = 1;
                else if (wipe)  m_flag[c] = 0;
                hist[c].push_front(pin_i[c]);
                void'(hist[c].pop_back());
            end
            if (bus_we_i && bus_addr_i == 6'h1D) m_mask = int'(bus_wdata_i[1:0]);
        end
    end

    task automatic compare();
        int pend [2];
        int req  [2];
        int exp_rd, exp_irq, exp_id;
        for (int c = 0; c < 2; c++) begin
            pend[c] = (sense_i[2*c +: 2] == 2'b00) ? int'(!hist[c][1]) : m_flag[c];
            req[c]  = pend[c] & ((m_mask >> c) & 1) & int'(gie_i);
        end
        if (bus_addr_i == 6'h1D)      exp_rd = m_mask;
        else if (bus_addr_i == 6'h1C) exp_rd = m_flag[0] | (m_flag[1] << 1);
        else                          exp_rd = 0;
        exp_irq = req[0] | req[1];
        exp_id  = req[0] ? 1 : (req[1] ? 2 : 0);
        n_cmp++;
        if (int'(bus_rdata_o) != exp_rd || int'(irq_o) != exp_irq || int'(irq_id_o) != exp_id) begin
            n_bad++;
            $display("FAIL %s t=%0t addr=%h rdata=%h/%h irq=%0d/%0d id=%0d/%0d (actual/expected)",
                     tag, $time, bus_addr_i, bus_rdata_o, exp_rd[7:0], irq_o, exp_irq, irq_id_o, exp_id);
        end
    endtask

    task automatic cyc(int n = 1);
        repeat (n) begin
            @(negedge clk);
            if (rst_n) compare();
        end
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        bus_addr_i  = a;
        bus_wdata_i = d;
        bus_we_i    = 1'b1;
        cyc();
        bus_we_i    = 1'b0;
        bus_addr_i  = 6'h1C;
    endtask

    task automatic peek_both();
        bus_addr_i = 6'h1C; cyc();
        bus_addr_i = 6'h1D; cyc();
        bus_addr_i = 6'h1C;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pin_i = '0; sense_i = '0; gie_i = 1'b0;
        bus_addr_i = 6'h1C; bus_we_i = 1'b0; bus_wdata_i = '0; ack_i = '0;
        cyc(3);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset values
        tag = "R1"; peek_both();

        // R2 register map, reserved bits and unmapped addresses
        tag = "R2";
        wr(6'h1D, 8'hFF); peek_both();
        wr(6'h05, 8'hFF); bus_addr_i = 6'h05; cyc(); bus_addr_i = 6'h00; cyc();
        wr(6'h1D, 8'hFE); peek_both();
        wr(6'h1D, 8'h00); peek_both();

        // R3 each edge code on both channels, various pin patterns
        tag = "R3";
        for (int mode = 1; mode < 4; mode++) begin
            sense_i = {mode[1:0], mode[1:0]};
            for (int k = 0; k < 6; k++) begin
                pin_i = {k[0], k[1]};
                for (int j = 0; j < 4; j++) peek_both();
                wr(6'h1C, 8'h03); cyc(2);
            end
            pin_i = 2'b00; cyc(4); wr(6'h1C, 8'h03);
        end

        // R10 flags latch while masked and disabled
        tag = "R10";
        sense_i = 4'b1111; gie_i = 1'b0;
        pin_i = 2'b11; cyc(4); peek_both();
        wr(6'h1D, 8'h03); cyc(2);

        // R4 request gating by mask and global enable
        tag = "R4";
        gie_i = 1'b1; cyc(2);
        wr(6'h1D, 8'h01); cyc(2);
        wr(6'h1D, 8'h02); cyc(2);
        gie_i = 1'b0; cyc(2); gie_i = 1'b1;
        wr(6'h1D, 8'h00); cyc(2);
        wr(6'h1D, 8'h03); cyc(2);

        // R5 write-one clears, write-zero keeps
        tag = "R5";
        wr(6'h1C, 8'h00); cyc(2);
        wr(6'h1C, 8'hFC); cyc(2);
        wr(6'h1C, 8'h02); cyc(2);
        wr(6'h1C, 8'h01); cyc(2);

        // R6 acknowledge clears only the named channel
        tag = "R6";
        pin_i = 2'b00; cyc(3); pin_i = 2'b11; cyc(4);
        ack_i = 2'b01; cyc(); ack_i = 2'b00; cyc(2);
        ack_i = 2'b10; cyc(); ack_i = 2'b00; cyc(2);

        // R7 detection racing clears every cycle
        tag = "R7";
        sense_i = 4'b0101;
        for (int k = 0; k < 12; k++) begin
            pin_i = {k[1], k[0]};
            ack_i = k[2] ? 2'b11 : 2'b00;
            wr(6'h1C, 8'h03);
        end
        ack_i = 2'b00; pin_i = 2'b00; cyc(5);

        // R8 level mode: flag zero, request follows pin
        tag = "R8";
        sense_i = 4'b0101; pin_i = 2'b01; cyc(4);
        sense_i = 4'b0000; peek_both();
        for (int k = 0; k < 8; k++) begin
            pin_i = {k[2], k[0]};
            cyc(); wr(6'h1C, 8'h03);
        end
        gie_i = 1'b0; cyc(2); gie_i = 1'b1;

        // R9 priority when both channels request
        tag = "R9";
        pin_i = 2'b00; cyc(4);
        pin_i = 2'b01; cyc(4);
        pin_i = 2'b11; cyc(4);
        pin_i = 2'b10; cyc(4);
        wr(6'h1D, 8'h02); cyc(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule